// File: doc/BRIEF.md
# Cache Stall Cause Tracker

This block records the reasons a cache is currently refusing work and gathers stall statistics per reason. Two cause vectors are kept: one gates the access path and one gates the snoop path. A cause is added to either vector by a set pulse that carries a cause index. A single clear pulse removes a cause from both vectors together. Each vector drives a registered blocked flag. The access vector drives the flag toward the CPU-side port, and the snoop vector drives the flag toward the memory-side port.

A stall episode on the access path starts when the first cause appears in an empty access vector. It ends when a clear empties that vector again. The block counts how many episodes each cause opened. It also charges the length of each episode, in clock cycles, to the cause whose clear ended it. A free-running cycle counter supplies the time, and a start register holds the cycle in which the current episode opened. Software-independent readout is combinational: a cause index selects which pair of counters appears on the read outputs.

Top module: `stall_tracker`

## Requirements
- R1: There are five causes, numbered 0 to 4: no free miss register (0), no free miss target (1), no free writeback buffer (2), coherence (3) and copy (4). Cause n owns bit n of the 8-bit vectors `acc_vec` and `snp_vec`.
- R2: A set-access pulse with a valid index ORs its bit into `acc_vec`. The change is visible after the clock edge that samples the pulse. `cpu_blocked` is high in exactly the cycles in which `acc_vec` is nonzero.
- R3: A set-access pulse that arrives while `acc_vec` is zero adds one to that cause's episode count. A set-access pulse that arrives while `acc_vec` is nonzero leaves every episode count unchanged.
- R4: A set-snoop pulse ORs its bit into `snp_vec` and leaves `acc_vec` unchanged. `mem_blocked` is high in exactly the cycles in which `snp_vec` is nonzero.
- R5: A clear pulse removes its bit from `acc_vec` and from `snp_vec` at the same clock edge.
- R6: When a clear empties `acc_vec`, the number of clock edges between the edge that opened the episode and the edge that sampled the clear is added to the cycle count of the cause just cleared. No other cause is charged. A clear that leaves `acc_vec` nonzero charges nothing.
- R7: `mem_blocked` falls once a clear empties `snp_vec`, whatever `acc_vec` holds.
- R8: When a set pulse and a clear pulse name the same cause at the same edge, the set wins on the vector it targets. The clear still applies to the other vector.
- R9: A cause index of 5, 6 or 7 on any pulse is ignored. Bits 7 to 5 of both vectors stay zero, and no counter moves.
- R10: Episode and cycle counters are `CNT_W` bits wide (default 32) and saturate at all ones instead of wrapping.
- R11: A synchronous reset clears both vectors, both blocked flags, all counters, the cycle counter and the start register.
- R12: `rd_idx` selects the cause whose episode count and cycle count appear combinationally on `rd_episodes` and `rd_cycles`. An index of 5 or more reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_acc_vld | input | 1 | Add a cause to the access vector |
| set_acc_idx | input | 3 | Cause index for set_acc_vld |
| set_snp_vld | input | 1 | Add a cause to the snoop vector |
| set_snp_idx | input | 3 | Cause index for set_snp_vld |
| clr_vld | input | 1 | Remove a cause from both vectors |
| clr_idx | input | 3 | Cause index for clr_vld |
| rd_idx | input | 3 | Cause selected for counter readout |
| acc_vec | output | 8 | Access-path cause vector |
| snp_vec | output | 8 | Snoop-path cause vector |
| cpu_blocked | output | 1 | CPU-side port blocked |
| mem_blocked | output | 1 | Memory-side port blocked |
| rd_episodes | output | CNT_W | Episode count of the selected cause |
| rd_cycles | output | CNT_W | Blocked-cycle count of the selected cause |

## Verification
The pulse sequences fall into four groups.

- **Single cause:** set and clear of one cause on an empty tracker shows the basic vector and flag behaviour.
- **Overlapping causes:** a second cause is set while the first is held, and the causes are cleared in both orders. This separates "charged to the last cause cleared" from "charged to the opening cause", and "counted on the first set" from "counted on every set".
- **Snoop interplay:** snoop-only sets are followed by clears. This shows that one clear empties both paths and that the two flags fall independently.
- **Same-edge and edge-value pulses:** set and clear of the same cause at one edge, indices 5 to 7, and long or repeated episodes on a bench instance with 4-bit counters. These cover precedence, ignored indices and saturation.

// File: rtl/stall_pkg.sv
package stall_pkg;
    localparam int NUM_CAUSES = 5;
    localparam int VEC_W      = 8;
    localparam int IDX_W      = 3;

    typedef enum logic [IDX_W-1:0] {
        CAUSE_NO_MISS_REG = 3'd0,
        CAUSE_NO_MISS_TGT = 3'd1,
        CAUSE_NO_WB_BUF   = 3'd2,
        CAUSE_COHERENCE   = 3'd3,
        CAUSE_COPY        = 3'd4
    } stall_cause_e;

    // One-hot bit for a valid cause, zero for an absent pulse or index >= NUM_CAUSES
    function automatic logic [VEC_W-1:0] cause_mask(input logic vld,
                                                    input logic [IDX_W-1:0] idx);
        if (vld && (idx < IDX_W'(NUM_CAUSES)))
            return VEC_W'(1) << idx;
        return '0;
    endfunction
endpackage

// File: rtl/stall_vec_ctrl.sv
module stall_vec_ctrl
    import stall_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_acc_vld,
    input  logic [IDX_W-1:0] set_acc_idx,
    input  logic             set_snp_vld,
    input  logic [IDX_W-1:0] set_snp_idx,
    input  logic             clr_vld,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [VEC_W-1:0] acc_o,
    output logic [VEC_W-1:0] snp_o,
    output logic             open_vld,
    output logic [IDX_W-1:0] open_idx,
    output logic             close_vld,
    output logic [IDX_W-1:0] close_idx
);
    typedef struct packed {
        logic [VEC_W-1:0] acc;
        logic [VEC_W-1:0] snp;
    } vec_state_t;

    vec_state_t st_d, st_q;
    logic [VEC_W-1:0] acc_set_m, snp_set_m, clr_m;

    always_comb begin
        acc_set_m = cause_mask(set_acc_vld, set_acc_idx);
        snp_set_m = cause_mask(set_snp_vld, set_snp_idx);
        clr_m     = cause_mask(clr_vld, clr_idx);
        // set is applied after clear: the set wins on its own vector
        st_d.acc  = (st_q.acc & ~clr_m) | acc_set_m;
        st_d.snp  = (st_q.snp & ~clr_m) | snp_set_m;
        open_vld  = (acc_set_m != '0) && (st_q.acc == '0);
        open_idx  = set_acc_idx;
        close_vld = (st_q.acc != '0) && (st_d.acc == '0);
        close_idx = clr_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign snp_o = st_q.snp;
endmodule

// File: rtl/stall_stat_bank.sv
module stall_stat_bank
    import stall_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_vld,
    input  logic [IDX_W-1:0]  open_idx,
    input  logic              close_vld,
    input  logic [IDX_W-1:0]  close_idx,
    input  logic [TIME_W-1:0] close_amt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_ep,
    output logic [CNT_W-1:0]  rd_cyc
);
    localparam int SUM_W = ((TIME_W > CNT_W) ? TIME_W : CNT_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_CAUSES-1:0][CNT_W-1:0] ep;
        logic [NUM_CAUSES-1:0][CNT_W-1:0] cyc;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [NUM_CAUSES-1:0][CNT_W-1:0] ep_next, cyc_next;

    // per-cause saturating arithmetic
    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
        logic [SUM_W-1:0] cyc_sum;
        assign cyc_sum     = SUM_W'(st_q.cyc[g]) + SUM_W'(close_amt);
        assign ep_next[g]  = (st_q.ep[g] == CNT_MAX) ? CNT_MAX : st_q.ep[g] + CNT_W'(1);
        assign cyc_next[g] = (cyc_sum > SUM_W'(CNT_MAX)) ? CNT_MAX : cyc_sum[CNT_W-1:0];
    end

    always_comb begin
        st_d   = st_q;
        rd_ep  = '0;
        rd_cyc = '0;
        for (int i = 0; i < NUM_CAUSES; i++) begin
            if (open_vld && (open_idx == IDX_W'(i)))
                st_d.ep[i] = ep_next[i];
            if (close_vld && (close_idx == IDX_W'(i)))
                st_d.cyc[i] = cyc_next[i];
            if (rd_idx == IDX_W'(i)) begin
                rd_ep  = st_q.ep[i];
                rd_cyc = st_q.cyc[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
    import stall_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_acc_vld,
    input  logic [2:0]       set_acc_idx,
    input  logic             set_snp_vld,
    input  logic [2:0]       set_snp_idx,
    input  logic             clr_vld,
    input  logic [2:0]       clr_idx,
    input  logic [2:0]       rd_idx,
    output logic [7:0]       acc_vec,
    output logic [7:0]       snp_vec,
    output logic             cpu_blocked,
    output logic             mem_blocked,
    output logic [CNT_W-1:0] rd_episodes,
    output logic [CNT_W-1:0] rd_cycles
);
    typedef struct packed {
        logic [TIME_W-1:0] now;
        logic [TIME_W-1:0] start;
    } time_state_t;

    time_state_t tm_d, tm_q;
    logic             open_vld, close_vld;
    logic [IDX_W-1:0] open_idx, close_idx;
    logic [TIME_W-1:0] close_amt;

    stall_vec_ctrl u_vec (
        .clk         (clk),
        .rst         (rst),
        .set_acc_vld (set_acc_vld),
        .set_acc_idx (set_acc_idx),
        .set_snp_vld (set_snp_vld),
        .set_snp_idx (set_snp_idx),
        .clr_vld     (clr_vld),
        .clr_idx     (clr_idx),
        .acc_o       (acc_vec),
        .snp_o       (snp_vec),
        .open_vld    (open_vld),
        .open_idx    (open_idx),
        .close_vld   (close_vld),
        .close_idx   (close_idx)
    );

    always_comb begin
        tm_d     = tm_q;
        tm_d.now = tm_q.now + TIME_W'(1);
        if (open_vld) tm_d.start = tm_q.now;
        close_amt = tm_q.now - tm_q.start;
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    stall_stat_bank #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .open_vld  (open_vld),
        .open_idx  (open_idx),
        .close_vld (close_vld),
        .close_idx (close_idx),
        .close_amt (close_amt),
        .rd_idx    (rd_idx),
        .rd_ep     (rd_episodes),
        .rd_cyc    (rd_cycles)
    );

    assign cpu_blocked = |acc_vec;
    assign mem_blocked = |snp_vec;
endmodule

// File: rtl/stall_tracker_chk.sv
module stall_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       set_acc_vld,
    input logic [2:0] set_acc_idx,
    input logic       set_snp_vld,
    input logic [2:0] set_snp_idx,
    input logic       clr_vld,
    input logic [2:0] clr_idx,
    input logic [7:0] acc_vec,
    input logic [7:0] snp_vec,
    input logic       cpu_blocked
);
    AST_ACC_SET: assert property (@(posedge clk) disable iff (rst)
        (set_acc_vld && set_acc_idx < 3'd5) |=> (acc_vec[$past(set_acc_idx)] && cpu_blocked)); // R2

    AST_SNP_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (set_snp_vld && !set_acc_vld && !clr_vld) |=> (acc_vec == $past(acc_vec))); // R4

    AST_CLR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && clr_idx < 3'd5 && !(set_acc_vld && set_acc_idx == clr_idx)
         && !(set_snp_vld && set_snp_idx == clr_idx))
        |=> (!acc_vec[$past(clr_idx)] && !snp_vec[$past(clr_idx)])); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_acc_vld && clr_vld && set_acc_idx == clr_idx && clr_idx < 3'd5)
        |=> acc_vec[$past(clr_idx)]); // R8

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_vec[7:5] == 3'b000) && (snp_vec[7:5] == 3'b000)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (acc_vec == 8'h00 && snp_vec == 8'h00)); // R11
endmodule

bind stall_tracker stall_tracker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .set_acc_vld (set_acc_vld),
    .set_acc_idx (set_acc_idx),
    .set_snp_vld (set_snp_vld),
    .set_snp_idx (set_snp_idx),
    .clr_vld     (clr_vld),
    .clr_idx     (clr_idx),
    .acc_vec     (acc_vec),
    .snp_vec     (snp_vec),
    .cpu_blocked (cpu_blocked)
);

// File: tb/stall_tracker_bench.sv
`timescale 1ns/1ps
module stall_tracker_bench;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_acc_vld = 1'b0, set_snp_vld = 1'b0, clr_vld = 1'b0;
    logic [2:0]    set_acc_idx = '0, set_snp_idx = '0, clr_idx = '0, rd_idx = '0;
    logic [7:0]    acc_vec, snp_vec;
    logic          cpu_blocked, mem_blocked;
    logic [CW-1:0] rd_episodes, rd_cycles;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    stall_tracker #(.CNT_W(CW), .TIME_W(32)) u_stall_tracker (
        .clk(clk), .rst(rst),
        .set_acc_vld(set_acc_vld), .set_acc_idx(set_acc_idx),
        .set_snp_vld(set_snp_vld), .set_snp_idx(set_snp_idx),
        .clr_vld(clr_vld), .clr_idx(clr_idx), .rd_idx(rd_idx),
        .acc_vec(acc_vec), .snp_vec(snp_vec),
        .cpu_blocked(cpu_blocked), .mem_blocked(mem_blocked),
        .rd_episodes(rd_episodes), .rd_cycles(rd_cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input logic [2:0] idx,
                           input int ep, input int cyc);
        rd_idx = idx;
        #0.5;
        chk({req, " episodes"}, 32'(rd_episodes), ep);
        chk({req, " cycles"},   32'(rd_cycles),   cyc);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one pulse set for one edge; returns at the next negedge
    task automatic pulse(input logic sav, input logic [2:0] sai,
                         input logic ssv, input logic [2:0] ssi,
                         input logic cv,  input logic [2:0] ci);
        set_acc_vld = sav; set_acc_idx = sai;
        set_snp_vld = ssv; set_snp_idx = ssi;
        clr_vld     = cv;  clr_idx     = ci;
        @(negedge clk);
        set_acc_vld = 1'b0; set_snp_vld = 1'b0; clr_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 acc_vec", acc_vec, 0);
        chk("R11 snp_vec", snp_vec, 0);
        chk("R11 flags", {cpu_blocked, mem_blocked}, 0);
        pulse(1, 3'd2, 1, 3'd1, 0, 0);
        idle(2);
        pulse(0, 0, 0, 0, 1, 3'd2);
        do_reset();
        chk("R11 acc after busy", acc_vec, 0);
        chk("R11 snp after busy", snp_vec, 0);
        for (int i = 0; i < 5; i++) chk_cnt("R11 counters", 3'(i), 0, 0);
    endtask

    task automatic t_set_access();
        do_reset();
        pulse(1, 3'd2, 0, 0, 0, 0);
        chk("R1 R2 acc_vec", acc_vec, 8'h04);
        chk("R2 cpu_blocked", cpu_blocked, 1);
        chk("R4 mem_blocked idle", mem_blocked, 0);
        chk_cnt("R3 first set", 3'd2, 1, 0);
        pulse(1, 3'd0, 0, 0, 0, 0);
        chk("R2 acc_vec two", acc_vec, 8'h05);
        chk_cnt("R3 second set no episode", 3'd0, 0, 0);
        chk_cnt("R3 opener unchanged", 3'd2, 1, 0);
    endtask

    task automatic t_charge_last();
        do_reset();
        pulse(1, 3'd1, 0, 0, 0, 0);     // edge 0 opens
        idle(3);
        pulse(1, 3'd3, 0, 0, 0, 0);     // edge 4
        idle(2);
        pulse(0, 0, 0, 0, 1, 3'd1);     // edge 7
        chk("R5 acc after first clear", acc_vec, 8'h08);
        chk("R6 still blocked", cpu_blocked, 1);
        chk_cnt("R6 no charge yet", 3'd1, 1, 0);
        idle(1);
        pulse(0, 0, 0, 0, 1, 3'd3);     // edge 9 closes
        chk("R6 cpu released", cpu_blocked, 0);
        chk_cnt("R6 charged to last", 3'd3, 0, 9);
        chk_cnt("R6 opener not charged", 3'd1, 1, 0);
    endtask

    task automatic t_snoop();
        do_reset();
        pulse(0, 0, 1, 3'd2, 0, 0);
        chk("R4 snp_vec", snp_vec, 8'h04);
        chk("R4 acc untouched", acc_vec, 0);
        chk("R4 mem_blocked", mem_blocked, 1);
        chk("R4 cpu_blocked", cpu_blocked, 0);
        chk_cnt("R4 no episode", 3'd2, 0, 0);
        pulse(1, 3'd2, 0, 0, 0, 0);
        pulse(0, 0, 0, 0, 1, 3'd2);
        chk("R5 both cleared", {acc_vec, snp_vec}, 0);
        chk("R7 mem released", mem_blocked, 0);
        pulse(1, 3'd1, 1, 3'd3, 0, 0);
        pulse(0, 0, 0, 0, 1, 3'd3);
        chk("R7 mem drops alone", mem_blocked, 0);
        chk("R7 cpu held", cpu_blocked, 1);
        chk("R7 acc kept", acc_vec, 8'h02);
    endtask

    task automatic t_collide();
        do_reset();
        pulse(1, 3'd1, 0, 0, 1, 3'd1);  // edge 0
        chk("R8 set beats clear", acc_vec, 8'h02);
        chk_cnt("R8 episode opened", 3'd1, 1, 0);
        pulse(0, 0, 1, 3'd1, 1, 3'd1);  // edge 1
        chk("R8 snoop set wins", snp_vec, 8'h02);
        chk("R8 access cleared", acc_vec, 0);
        chk_cnt("R8 charge one", 3'd1, 1, 1);
    endtask

    task automatic t_bad_index();
        do_reset();
        pulse(1, 3'd5, 1, 3'd7, 0, 0);
        chk("R9 acc ignores 5", acc_vec, 0);
        chk("R9 snp ignores 7", snp_vec, 0);
        chk("R9 flags", {cpu_blocked, mem_blocked}, 0);
        pulse(1, 3'd2, 0, 0, 0, 0);
        pulse(0, 0, 0, 0, 1, 3'd6);
        chk("R9 clear 6 ignored", acc_vec, 8'h04);
        for (int i = 5; i < 8; i++) chk_cnt("R12 out of range", 3'(i), 0, 0);
        chk_cnt("R12 selected", 3'd2, 1, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int k = 0; k < 17; k++) begin
            pulse(1, 3'd4, 0, 0, 0, 0);
            pulse(0, 0, 0, 0, 1, 3'd4);
        end
        chk_cnt("R10 episodes saturate", 3'd4, 15, 15);
        pulse(1, 3'd0, 0, 0, 0, 0);
        idle(20);
        pulse(0, 0, 0, 0, 1, 3'd0);
        chk_cnt("R10 cycles saturate", 3'd0, 1, 15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_access();
        t_charge_last();
        t_snoop();
        t_collide();
        t_bad_index();
        t_saturate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule